// File: doc/BRIEF.md
# UART Receive Status and Interrupt Logic

This block sits between a UART receive shift engine and a processor bus. When the engine signals that a character is complete, the block sorts the character by its error indications and the two enable bits in its status register, and either loads the character into a one-entry receive buffer or drops it. It keeps an 8-bit sticky status register. The register holds four error flags, an erroneous-character interrupt enable, an address-only wake enable, a flag for the kind of the last character, and a summary error flag.

Software reaches the block through a small register port. `reg_sel` picks the status register (0) or the receive buffer (1) for reading. Writes go to the status register only. A separate `buf_rd` strobe marks the moment the buffer is consumed. A buffer read clears the receive interrupt flag, the summary error flag and the buffer-occupied state. The interrupt output is the receive flag gated by an external enable.

Top module: `uart_rx_status`

## Requirements
- R1: After a synchronous reset, the status register, the receive buffer, the receive flag and `rx_irq` are all 0.
- R2: A completed character with `stop_low` set sets status bit 7, the framing flag, in the next cycle.
- R3: A completed character with `par_bad` set while `par_en` is 1 sets status bit 6, the parity flag. Bit 6 always reads as 0 while `par_en` is 0.
- R4: A completed character that arrives while the buffer holds an unread character sets status bit 5, the overrun flag. A buffer is unread when it was loaded and `buf_rd` has not pulsed since, and a `buf_rd` in the same cycle counts as a read.
- R5: A completed character with `brk_seen` set sets status bit 4, the break flag.
- R6: A status write (`reg_wr` with `reg_sel`=0) loads all 8 bits, and error flags stay set until software writes 0 to them. When hardware sets a flag in the same cycle as a write, the hardware set wins.
- R7: A character is erroneous when any of framing, enabled parity, overrun or break applies. With status bit 3 at 0, an erroneous character is rejected: the buffer keeps its old contents and the receive flag is not set. With bit 3 at 1, it is loaded into the buffer like any other character.
- R8: With status bit 2 at 0, every accepted character sets the receive flag. With bit 2 at 1, only characters with `is_addr` set do. An erroneous address character with bit 3 at 0 sets nothing.
- R9: Status bit 1 takes the value of `is_addr` for every completed character, including rejected ones.
- R10: Status bit 0, the summary error flag, is set by any erroneous character. It clears when `buf_rd` pulses, unless a new error arrives in the same cycle.
- R11: With `reg_sel`=1, `reg_rdata` returns the last accepted character.
- R12: `buf_rd` clears the receive flag unless a character sets it in the same cycle. `rx_irq` equals the receive flag ANDed with `irq_en`.
- R13: Status bits 3 and 2 change only through software writes and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_done | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | DATA_W | Character value |
| stop_low | input | 1 | Stop bit was sampled low |
| par_bad | input | 1 | Parity mismatch on this character |
| brk_seen | input | 1 | Break condition on this character |
| is_addr | input | 1 | Character is an address character |
| par_en | input | 1 | Parity checking enabled |
| reg_sel | input | 1 | Read select: 0 status, 1 buffer |
| reg_wr | input | 1 | Write strobe for the status register (with reg_sel=0) |
| reg_wdata | input | 8 | Status write data |
| buf_rd | input | 1 | Buffer consumed strobe |
| irq_en | input | 1 | External receive interrupt enable |
| reg_rdata | output | 8 | Read data |
| rx_flag | output | 1 | Receive interrupt flag |
| rx_irq | output | 1 | Gated receive interrupt |

## Verification
The bench targets the collisions that are easy to get wrong:
- A break arriving in the same cycle as a software write of zero. A design that lets the write win loses the flag.
- A new character arriving with no read in between. A design without an occupied state never reports overrun.
- An address character that carries an error while wake mode is on and erroneous characters are rejected. A design that checks only the address bit raises an interrupt.

The bench also reads parity status with parity disabled, where an unmasked flag would show up. It confirms that the summary flag drops on a buffer read while the individual flags stay. A design that tied the summary flag to the OR of the others would keep it high.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;

    localparam int STAT_W  = 8;
    localparam int ERR_N   = 4;
    localparam int ERR_LSB = 4;
    localparam int B_FE    = 7;
    localparam int B_PE    = 6;
    localparam int B_OE    = 5;
    localparam int B_BRK   = 4;
    localparam int B_EIE   = 3;
    localparam int B_WIE   = 2;
    localparam int B_WAKE  = 1;
    localparam int B_ERR   = 0;

    // errs[3]=framing, [2]=parity, [1]=overrun, [0]=break (mirrors bits 7..4)
    typedef struct packed {
        logic             valid;
        logic [ERR_N-1:0] errs;
        logic             any_err;
        logic             accept;
        logic             raise;
        logic             is_addr;
    } rx_evt_t;

    // Priority: hardware set, then hardware clear, then software write.
    function automatic logic flag_next(input logic q, input logic hw_set,
                                       input logic hw_clr, input logic sw_wr,
                                       input logic sw_val);
        if (hw_set)      return 1'b1;
        else if (hw_clr) return 1'b0;
        else if (sw_wr)  return sw_val;
        else             return q;
    endfunction

endpackage

// File: rtl/uart_rx_classify.sv
module uart_rx_classify
    import uart_rx_status_pkg::*;
(
    input  logic    char_done,
    input  logic    stop_low,
    input  logic    par_bad,
    input  logic    brk_seen,
    input  logic    is_addr,
    input  logic    par_en,
    input  logic    buf_full,
    input  logic    buf_rd,
    input  logic    eie,
    input  logic    wie,
    output rx_evt_t evt
);
    logic [ERR_N-1:0] raw;

    always_comb begin
        raw[3] = stop_low;
        raw[2] = par_bad & par_en;
        raw[1] = buf_full & ~buf_rd;
        raw[0] = brk_seen;
        evt.valid   = char_done;
        evt.is_addr = is_addr;
        evt.errs    = char_done ? raw : '0;
        evt.any_err = |evt.errs;
        evt.accept  = char_done & (~evt.any_err | eie);
        evt.raise   = evt.accept & (~wie | is_addr);
    end
endmodule

// File: rtl/uart_rx_status_reg.sv
module uart_rx_status_reg
    import uart_rx_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic              buf_rd,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] sw_data,
    output logic [STAT_W-1:0] stat_q
);
    for (genvar i = 0; i < ERR_N; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst) stat_q[ERR_LSB+i] <= 1'b0;
            else     stat_q[ERR_LSB+i] <= flag_next(stat_q[ERR_LSB+i], evt.errs[i],
                                                    1'b0, sw_wr, sw_data[ERR_LSB+i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q[B_EIE:B_ERR] <= '0;
        end else begin
            stat_q[B_EIE]  <= flag_next(stat_q[B_EIE], 1'b0, 1'b0, sw_wr, sw_data[B_EIE]);
            stat_q[B_WIE]  <= flag_next(stat_q[B_WIE], 1'b0, 1'b0, sw_wr, sw_data[B_WIE]);
            stat_q[B_WAKE] <= flag_next(stat_q[B_WAKE], evt.valid & evt.is_addr,
                                        evt.valid & ~evt.is_addr, sw_wr, sw_data[B_WAKE]);
            stat_q[B_ERR]  <= flag_next(stat_q[B_ERR], evt.any_err, buf_rd,
                                        sw_wr, sw_data[B_ERR]);
        end
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_q[B_FE] && !sw_wr) |=> stat_q[B_FE]);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic [DATA_W-1:0] char_data,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] data_q,
    output logic              full_q,
    output logic              flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (evt.accept) data_q <= char_data;
            full_q <= flag_next(full_q, evt.accept, buf_rd, 1'b0, 1'b0);
            flag_q <= flag_next(flag_q, evt.raise, buf_rd, 1'b0, 1'b0);
        end
    end

    p_full_r4: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> full_q);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              stop_low,
    input  logic              par_bad,
    input  logic              brk_seen,
    input  logic              is_addr,
    input  logic              par_en,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              buf_rd,
    input  logic              irq_en,
    output logic [7:0]        reg_rdata,
    output logic              rx_flag,
    output logic              rx_irq
);
    rx_evt_t           evt;
    logic [STAT_W-1:0] stat;
    logic [STAT_W-1:0] stat_view;
    logic [DATA_W-1:0] buf_data;
    logic              buf_full;
    logic              sw_wr;

    assign sw_wr = reg_wr & ~reg_sel;

    uart_rx_classify u_cls (
        .char_done (char_done),
        .stop_low  (stop_low),
        .par_bad   (par_bad),
        .brk_seen  (brk_seen),
        .is_addr   (is_addr),
        .par_en    (par_en),
        .buf_full  (buf_full),
        .buf_rd    (buf_rd),
        .eie       (stat[B_EIE]),
        .wie       (stat[B_WIE]),
        .evt       (evt)
    );

    uart_rx_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .buf_rd  (buf_rd),
        .sw_wr   (sw_wr),
        .sw_data (reg_wdata),
        .stat_q  (stat)
    );

    uart_rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .char_data (char_data),
        .buf_rd    (buf_rd),
        .data_q    (buf_data),
        .full_q    (buf_full),
        .flag_q    (rx_flag)
    );

    always_comb begin
        stat_view       = stat;
        stat_view[B_PE] = stat[B_PE] & par_en;
        reg_rdata       = reg_sel ? STAT_W'(buf_data) : stat_view;
    end

    assign rx_irq = rx_flag & irq_en;

    p_fe_set_r2: assert property (@(posedge clk) disable iff (rst)
        (char_done && stop_low) |=> stat[B_FE]);
    p_ovr_set_r4: assert property (@(posedge clk) disable iff (rst)
        (char_done && buf_full && !buf_rd) |=> stat[B_OE]);
    p_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (char_done && (stop_low || brk_seen) && !stat[B_EIE]) |=> (buf_data == $past(buf_data)));
    p_wake_only_r8: assert property (@(posedge clk) disable iff (rst)
        (char_done && stat[B_WIE] && !is_addr && !rx_flag) |=> !rx_flag);
    p_wake_kind_r9: assert property (@(posedge clk) disable iff (rst)
        char_done |=> (stat[B_WAKE] == $past(is_addr)));
    p_sum_set_r10: assert property (@(posedge clk) disable iff (rst)
        (char_done && (stop_low || brk_seen)) |=> stat[B_ERR]);
    p_rd_clr_r12: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !char_done) |=> !rx_flag);
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
    logic clk = 1'b0, rst = 1'b1;
    logic char_done = 0, stop_low = 0, par_bad = 0, brk_seen = 0, is_addr = 0;
    logic par_en = 0, reg_sel = 0, reg_wr = 0, buf_rd = 0, irq_en = 1;
    logic [7:0] char_data = 0, reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic rx_flag, rx_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural model state
    bit m_fe, m_pe, m_oe, m_bk, m_eie, m_wie, m_wk, m_er, m_full, m_flag;
    byte unsigned m_buf;

    always #5 clk = ~clk;

    uart_rx_status #(.DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
        .stop_low(stop_low), .par_bad(par_bad), .brk_seen(brk_seen),
        .is_addr(is_addr), .par_en(par_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .buf_rd(buf_rd), .irq_en(irq_en),
        .reg_rdata(reg_rdata), .rx_flag(rx_flag), .rx_irq(rx_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_rdata();
        if (reg_sel) return int'(m_buf);
        return {m_fe, m_pe & par_en, m_oe, m_bk, m_eie, m_wie, m_wk, m_er};
    endfunction

    task automatic model_step();
        bit pe_e, ov, bad, acc, sw;
        if (rst) begin
            {m_fe, m_pe, m_oe, m_bk, m_eie, m_wie, m_wk, m_er, m_full, m_flag} = '0;
            m_buf = 0;
            return;
        end
        pe_e = par_bad && par_en;
        ov   = char_done && m_full && !buf_rd;
        bad  = char_done && (stop_low || pe_e || brk_seen || ov);
        acc  = char_done && (!bad || m_eie);
        sw   = reg_wr && !reg_sel;
        m_fe = (char_done && stop_low) ? 1 : sw ? reg_wdata[7] : m_fe;
        m_pe = (char_done && pe_e)     ? 1 : sw ? reg_wdata[6] : m_pe;
        m_oe = ov                      ? 1 : sw ? reg_wdata[5] : m_oe;
        m_bk = (char_done && brk_seen) ? 1 : sw ? reg_wdata[4] : m_bk;
        m_er = bad ? 1 : buf_rd ? 0 : sw ? reg_wdata[0] : m_er;
        m_wk = char_done ? is_addr : sw ? reg_wdata[1] : m_wk;
        if (acc && (!m_wie || is_addr)) m_flag = 1; else if (buf_rd) m_flag = 0;
        if (acc) begin m_buf = char_data; m_full = 1; end else if (buf_rd) m_full = 0;
        if (sw) begin m_eie = reg_wdata[3]; m_wie = reg_wdata[2]; end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        check("R2/R3/R4/R5/R6/R9/R10/R11/R13 model rdata", reg_rdata, model_rdata());
        check("R7/R8/R12 model flag", rx_flag, m_flag);
        check("R12 model irq", rx_irq, m_flag & irq_en);
        char_done = 0; stop_low = 0; par_bad = 0; brk_seen = 0; is_addr = 0;
        reg_wr = 0; buf_rd = 0;
    endtask

    task automatic send(input byte unsigned d, input bit sl, input bit pb,
                        input bit bk, input bit ad);
        char_done = 1; char_data = d; stop_low = sl; par_bad = pb;
        brk_seen = bk; is_addr = ad;
        tick();
    endtask

    task automatic wr_stat(input byte unsigned v);
        reg_sel = 0; reg_wr = 1; reg_wdata = v;
        tick();
    endtask

    task automatic rd_buf();
        buf_rd = 1;
        tick();
    endtask

    task automatic peek(input bit sel);
        reg_sel = sel;
        #1;
    endtask

    initial begin
        tick(); tick();
        rst = 0;
        peek(0); check("R1 status after reset", reg_rdata, 8'h00);
        peek(1); check("R1 buffer after reset", reg_rdata, 8'h00);
        check("R1 flag after reset", rx_flag, 0);

        send(8'h5A, 0, 0, 0, 0);
        check("R8 good char sets flag", rx_flag, 1);
        check("R12 irq follows flag", rx_irq, 1);
        peek(1); check("R11 buffer value", reg_rdata, 8'h5A);
        rd_buf();
        check("R12 read clears flag", rx_flag, 0);

        send(8'h33, 1, 0, 0, 0);
        peek(1); check("R7 rejected keeps buffer", reg_rdata, 8'h5A);
        check("R7 rejected no flag", rx_flag, 0);
        peek(0); check("R2 framing flag", reg_rdata[7], 1);
        check("R10 summary set", reg_rdata[0], 1);
        tick();
        peek(0); check("R6 flag sticky", reg_rdata[7], 1);

        wr_stat(8'h00);
        peek(0); check("R6 write 0 clears", reg_rdata, 8'h00);
        brk_seen = 1; char_done = 1; char_data = 8'h01; reg_sel = 0; reg_wr = 1; reg_wdata = 8'h00;
        tick();
        peek(0); check("R5 break flag with hw-wins R6", reg_rdata[4], 1);

        wr_stat(8'h08);
        par_en = 0;
        send(8'h11, 0, 1, 0, 0);
        peek(0); check("R3 parity masked when disabled", reg_rdata[6], 0);
        rd_buf();
        par_en = 1;
        send(8'h22, 0, 1, 0, 0);
        peek(0); check("R3 parity flag", reg_rdata[6], 1);
        peek(1); check("R7 erroneous accepted when enabled", reg_rdata, 8'h22);
        send(8'h44, 0, 0, 0, 0);
        peek(0); check("R4 overrun flag", reg_rdata[5], 1);
        rd_buf();
        peek(0); check("R10 summary clears on read", reg_rdata[0], 0);
        check("R10 individual flags stay", reg_rdata[5], 1);

        wr_stat(8'h04);
        par_en = 0;
        send(8'h66, 0, 0, 0, 0);
        check("R8 data char no flag in wake mode", rx_flag, 0);
        peek(0); check("R9 data kind", reg_rdata[1], 0);
        rd_buf();
        send(8'h77, 0, 0, 0, 1);
        check("R8 address char sets flag", rx_flag, 1);
        peek(0); check("R9 address kind", reg_rdata[1], 1);
        rd_buf();
        send(8'h88, 1, 0, 0, 1);
        check("R8 erroneous address rejected", rx_flag, 0);
        peek(1); check("R7 buffer kept", reg_rdata, 8'h77);

        wr_stat(8'h0C);
        peek(0); check("R13 enables read back", reg_rdata[3:2], 2'b11);
        send(8'h99, 0, 0, 0, 1);
        irq_en = 0;
        #1; check("R12 irq gated off", rx_irq, 0);
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule